// File: doc/BRIEF.md
# Mode-2 Interrupt Vector Generator

This block collects interrupt requests from three DMA channels and one raster source and drives a shared active-low interrupt line toward a Z80-style CPU. The raster source is itself the OR of two line events: a fixed periodic tick that fires every 52 scanlines and a programmable line-match event. Each source owns a pending latch. The latch is set by a one-cycle pulse and is held until that source is serviced.

When the CPU acknowledges the interrupt in vectored mode with interrupts enabled, the block captures the highest-priority pending source and clears that source's latch. For as long as the acknowledge lasts, it places an 8-bit vector on the data bus. The vector is built from three fields. The upper nibble comes from a CPU-writable base register. The middle three bits carry a code that identifies the source. Bit 0 is always zero, so the CPU can use the vector to index a table of 16-bit handler addresses.

The base register decodes at address 0x6805. It is written with a single-cycle write strobe.

Top module: `vecirq_gen`

## Requirements
- R1: After reset, irq_n is high and vec_oe is low. The base register holds 0x01, so the first vector driven after reset has upper nibble 0.
- R2: A pulse on ras_periodic or on ras_match sets the raster pending latch. Pulses on both inputs in the same cycle produce one pending raster request, and one acknowledge services it.
- R3: A one-cycle request pulse sets that source's latch at the next clock edge. irq_n is low whenever at least one latch is set.
- R4: An acknowledge is m1_n and iorq_n both low. vec_oe goes high from the first clock edge at which the acknowledge is seen. It stays high until m1_n or iorq_n returns high, and it drops combinationally at that moment. vec_oe is low at all other times.
- R5: The vector is driven, and a latch is cleared, only when im2_mode and int_en are both high and at least one request is pending at the edge where the acknowledge is first seen. Otherwise vec_oe stays low and every pending latch is kept.
- R6: The vector has three fields. Bits 7..4 equal bits 7..4 of the base register. Bits 3..1 hold the source code: raster = 3'b011, DMA0 = 3'b010, DMA1 = 3'b001, DMA2 = 3'b000. Bit 0 is 0.
- R7: When several requests are pending, the order of service is raster first, then DMA0, then DMA1, then DMA2.
- R8: An accepted acknowledge clears only the serviced source's latch and leaves the others set. irq_n returns high once no latch remains set.
- R9: The vector is frozen at the start of the acknowledge. A request arriving during the acknowledge, even one of higher priority, does not change the driven vector. That request is still latched.
- R10: A write strobe with cpu_addr = 0x6805 loads cpu_wdata into the base register at the next edge and leaves all pending latches unchanged. A write to any other address leaves the base register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address for register writes |
| cpu_wr | input | 1 | One-cycle register write strobe |
| cpu_wdata | input | 8 | Register write data |
| m1_n | input | 1 | CPU opcode-fetch/acknowledge marker, active low |
| iorq_n | input | 1 | CPU I/O request, active low |
| im2_mode | input | 1 | CPU is in vectored interrupt mode |
| int_en | input | 1 | CPU maskable interrupts enabled |
| dma_req | input | 3 | One-cycle request pulses, bit 0 = DMA0 |
| ras_periodic | input | 1 | 52-scanline periodic raster pulse |
| ras_match | input | 1 | Programmable line-match raster pulse |
| irq_n | output | 1 | Interrupt request to CPU, active low |
| vec_out | output | 8 | Vector value for the data bus |
| vec_oe | output | 1 | Data bus drive enable for vec_out |

## Verification
The assertions assume that request inputs are single-cycle pulses. They also assume that im2_mode and int_en are stable around the clock edge that first sees an acknowledge, and that m1_n and iorq_n fall together and stay low for whole cycles. The bench changes every input on the falling clock edge and samples the outputs on the following falling edge. It holds the mode and enable levels constant across each acknowledge and releases both bus strobes together, so the stimulus stays within these assumptions. The sweep covers every base nibble against every non-empty set of pending sources, and it checks the full service order for each set.

// File: rtl/vecirq_pkg.sv
package vecirq_pkg;

   // Acknowledge tracker states
   typedef enum logic [1:0] {
      ACK_IDLE  = 2'd0,   // no acknowledge in progress
      ACK_DRIVE = 2'd1,   // accepted acknowledge, vector on bus
      ACK_MUTE  = 2'd2    // acknowledge seen but not accepted
   } ack_st_t;

   // Source code: the highest-priority index (0) receives the largest code
   function automatic int unsigned vi_src_code(input int unsigned idx,
                                               input int unsigned nsrc);
      return nsrc - 1 - idx;
   endfunction

endpackage

// File: rtl/vecirq_basereg.sv
module vecirq_basereg #(
   parameter int unsigned          DATA_W   = 8,
   parameter int unsigned          ADDR_W   = 16,
   parameter logic [ADDR_W-1:0]    REG_ADDR = 16'h6805,
   parameter logic [DATA_W-1:0]    RST_VAL  = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] base_o
);

   logic hit;

   assign hit = wr_i && (addr_i == REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   base_o <= RST_VAL;
      else if (hit) base_o <= wdata_i;
   end

   // R10: a decoded write lands on the next edge
   a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == REG_ADDR) |=> (base_o == $past(wdata_i)));

   // R10: no other access changes the register
   a_r10_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && addr_i == REG_ADDR) |=> $stable(base_o));

endmodule

// File: rtl/vecirq_pend.sv
module vecirq_pend #(
   parameter int unsigned NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] pend_o
);

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_lat
         // A set in the same cycle as a clear wins, so no request is lost
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pend_o[g] <= 1'b0;
            else if (set_i[g])  pend_o[g] <= 1'b1;
            else if (clr_i[g])  pend_o[g] <= 1'b0;
         end

         // R3: a pulse is always captured
         a_r3_pulse_latched: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]);

         // R8: an uncleared pending request survives
         a_r8_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
      end
   endgenerate

endmodule

// File: rtl/vecirq_prio.sv
module vecirq_prio #(
   parameter int unsigned NSRC  = 4,
   parameter int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  req_i,
   output logic [NSRC-1:0]  grant_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);

   logic [NSRC-1:0] blocked;

   // Fixed priority chain: index 0 highest
   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_chain
         if (g == 0) begin : g_head
            assign blocked[g] = 1'b0;
         end else begin : g_link
            assign blocked[g] = blocked[g-1] | req_i[g-1];
         end
         assign grant_o[g] = req_i[g] & ~blocked[g];
      end
   endgenerate

   assign any_o = |req_i;

   always_comb begin
      idx_o = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (grant_o[i]) idx_o = IDX_W'(i);
      end
   end

   // R7: at most one source wins
   a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R7: some source wins whenever any is pending
   a_r7_grant_when_req: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_i) |-> (|grant_o));

endmodule

// File: rtl/vecirq_ackctl.sv
module vecirq_ackctl
   import vecirq_pkg::*;
#(
   parameter int unsigned NSRC   = 4,
   parameter int unsigned CODE_W = 3,
   parameter int unsigned IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m1_n,
   input  logic              iorq_n,
   input  logic              mode2_i,
   input  logic              ie_i,
   input  logic              any_i,
   input  logic [NSRC-1:0]   grant_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic              drive_o,
   output logic [NSRC-1:0]   clr_o,
   output logic [CODE_W-1:0] code_o
);

   localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(vi_src_code(0, NSRC));

   ack_st_t           st_q;
   logic              ack;
   logic              accept;
   logic [CODE_W-1:0] cur_code;

   assign ack      = !m1_n && !iorq_n;
   assign accept   = (st_q == ACK_IDLE) && ack && mode2_i && ie_i && any_i;
   assign cur_code = TOP_CODE - CODE_W'(idx_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ACK_IDLE;
         code_o <= '0;
      end else begin
         case (st_q)
            ACK_IDLE: begin
               if (ack) st_q <= accept ? ACK_DRIVE : ACK_MUTE;
               if (accept) code_o <= cur_code;
            end
            ACK_DRIVE,
            ACK_MUTE: begin
               if (!ack) st_q <= ACK_IDLE;
            end
            default: st_q <= ACK_IDLE;
         endcase
      end
   end

   assign clr_o   = accept ? grant_i : '0;
   assign drive_o = (st_q == ACK_DRIVE) && ack;

   // R4: the drive enable never appears outside an acknowledge
   a_r4_drive_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
      drive_o |-> (!m1_n && !iorq_n));

   // R5: an acknowledge outside vectored-enabled mode is never driven
   a_r5_gated_by_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ACK_IDLE && ack && !(mode2_i && ie_i)) |=> !drive_o);

   // R8: one acknowledge services at most one source
   a_r8_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o));

endmodule

// File: rtl/vecirq_gen.sv
module vecirq_gen #(
   parameter int unsigned          DATA_W       = 8,
   parameter int unsigned          ADDR_W       = 16,
   parameter int unsigned          NUM_DMA      = 3,
   parameter int unsigned          CODE_W       = 3,
   parameter logic [ADDR_W-1:0]    VEC_REG_ADDR = 16'h6805,
   parameter logic [DATA_W-1:0]    BASE_RST     = 8'h01
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic               cpu_wr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   input  logic               m1_n,
   input  logic               iorq_n,
   input  logic               im2_mode,
   input  logic               int_en,
   input  logic [NUM_DMA-1:0] dma_req,
   input  logic               ras_periodic,
   input  logic               ras_match,
   output logic               irq_n,
   output logic [DATA_W-1:0]  vec_out,
   output logic               vec_oe
);

   localparam int unsigned NSRC  = NUM_DMA + 1;
   localparam int unsigned IDX_W = $clog2(NSRC);
   localparam int unsigned HI_W  = DATA_W - CODE_W - 1;

   // Elaboration-time parameter checks
   generate
      if (NUM_DMA < 1) begin : g_chk_dma
         $error("vecirq_gen: NUM_DMA must be at least 1");
      end
      if (NSRC > (1 << CODE_W)) begin : g_chk_code
         $error("vecirq_gen: CODE_W too narrow for the source count");
      end
      if (DATA_W < CODE_W + 2) begin : g_chk_data
         $error("vecirq_gen: DATA_W leaves no room for the base field");
      end
   endgenerate

   logic [NSRC-1:0]   req;
   logic [NSRC-1:0]   pend;
   logic [NSRC-1:0]   grant;
   logic [NSRC-1:0]   clr;
   logic [IDX_W-1:0]  idx;
   logic              any_pend;
   logic [CODE_W-1:0] code_q;
   logic [DATA_W-1:0] base_q;
   logic [CODE_W:0]   unused_base_lo;

   // Index 0 is the merged raster source, DMA channels follow in order
   assign req = {dma_req, ras_periodic | ras_match};

   vecirq_basereg #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .REG_ADDR (VEC_REG_ADDR),
      .RST_VAL  (BASE_RST)
   ) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cpu_wr),
      .addr_i  (cpu_addr),
      .wdata_i (cpu_wdata),
      .base_o  (base_q)
   );

   vecirq_pend #(.NSRC(NSRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (req),
      .clr_i  (clr),
      .pend_o (pend)
   );

   vecirq_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (pend),
      .grant_o (grant),
      .idx_o   (idx),
      .any_o   (any_pend)
   );

   vecirq_ackctl #(.NSRC(NSRC), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_ack (
      .clk     (clk),
      .rst_n   (rst_n),
      .m1_n    (m1_n),
      .iorq_n  (iorq_n),
      .mode2_i (im2_mode),
      .ie_i    (int_en),
      .any_i   (any_pend),
      .grant_i (grant),
      .idx_i   (idx),
      .drive_o (vec_oe),
      .clr_o   (clr),
      .code_o  (code_q)
   );

   assign unused_base_lo = base_q[CODE_W:0];
   assign vec_out = {base_q[DATA_W-1 -: HI_W], code_q, 1'b0};
   assign irq_n   = ~any_pend;

   // R6: the low vector bit is never set while driven
   a_r6_bit0_low: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> !vec_out[0]);

   // R9: the vector holds still across a continuing acknowledge
   a_r9_vector_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_oe && $past(vec_oe)) |-> $stable(vec_out));

   // R3: any request pulls the interrupt line low on the next edge
   a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |=> !irq_n);

endmodule

// File: tb/sim_vecirq_gen.sv
module sim_vecirq_gen;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic        m1_n = 1'b1;
   logic        iorq_n = 1'b1;
   logic        im2_mode = 1'b1;
   logic        int_en = 1'b1;
   logic [2:0]  dma_req = '0;
   logic        ras_periodic = 1'b0;
   logic        ras_match = 1'b0;
   logic        irq_n;
   logic [7:0]  vec_out;
   logic        vec_oe;

   int checks = 0;
   int errs = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   vecirq_gen u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .m1_n(m1_n), .iorq_n(iorq_n),
      .im2_mode(im2_mode), .int_en(int_en), .dma_req(dma_req),
      .ras_periodic(ras_periodic), .ras_match(ras_match),
      .irq_n(irq_n), .vec_out(vec_out), .vec_oe(vec_oe)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // mask bit 0 = raster (periodic input), bits 1..3 = DMA0..DMA2
   task automatic pulse(input logic [3:0] m);
      @(negedge clk);
      ras_periodic = m[0];
      dma_req = m[3:1];
      @(negedge clk);
      ras_periodic = 1'b0;
      dma_req = '0;
   endtask

   task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   // Acknowledge with an optional injection in the first acknowledge cycle
   task automatic do_ack(input logic [3:0] inj, output logic oe1, output logic [7:0] v1,
                         output logic oe2, output logic [7:0] v2, output logic oe3);
      @(negedge clk);
      m1_n = 1'b0; iorq_n = 1'b0;
      ras_periodic = inj[0]; dma_req = inj[3:1];
      @(negedge clk);
      ras_periodic = 1'b0; dma_req = '0;
      oe1 = vec_oe; v1 = vec_out;
      @(negedge clk);
      oe2 = vec_oe; v2 = vec_out;
      m1_n = 1'b1; iorq_n = 1'b1;
      #1;
      oe3 = vec_oe;
   endtask

   function automatic int lowest(input logic [3:0] p);
      for (int i = 3; i >= 0; i--) if (p[i]) lowest = i;
   endfunction

   function automatic logic [7:0] exp_vec(input logic [3:0] nib, input int idx);
      return {nib, 3'(3 - idx), 1'b0};
   endfunction

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic oe1, oe2, oe3;
      logic [7:0] v1, v2;
      logic [3:0] p;
      int id;

      repeat (3) @(negedge clk);
      chk("R1 irq_n in reset", irq_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq_n after reset", irq_n, 1);
      chk("R1 vec_oe after reset", vec_oe, 0);

      // R1: first vector uses reset base 0x01 -> nibble 0; DMA2 code 000
      pulse(4'b1000);
      do_ack(4'b0000, oe1, v1, oe2, v2, oe3);
      chk("R1 reset base vector", v1, 8'h00);
      chk("R4 oe during ack", oe1, 1);
      chk("R4 oe drops on release", oe3, 0);
      chk("R8 irq_n released", irq_n, 1);

      // R5: nothing pending -> no drive
      do_ack(4'b0000, oe1, v1, oe2, v2, oe3);
      chk("R5 empty ack no drive", oe1, 0);

      // R2: each raster input alone, then both together
      @(negedge clk); ras_match = 1'b1; @(negedge clk); ras_match = 1'b0;
      chk("R2 match sets raster", irq_n, 0);
      do_ack(4'b0000, oe1, v1, oe2, v2, oe3);
      chk("R2 match vector", v1, 8'h06);
      chk("R2 match cleared", irq_n, 1);
      @(negedge clk); ras_match = 1'b1; ras_periodic = 1'b1;
      @(negedge clk); ras_match = 1'b0; ras_periodic = 1'b0;
      do_ack(4'b0000, oe1, v1, oe2, v2, oe3);
      chk("R2 merged vector", v1, 8'h06);
      chk("R2 merged single ack clears", irq_n, 1);

      // R5: mode and enable gating keep the latch
      pulse(4'b0010);
      im2_mode = 1'b0;
      do_ack(4'b0000, oe1, v1, oe2, v2, oe3);
      chk("R5 no drive outside mode 2", oe1, 0);
      chk("R5 latch kept outside mode 2", irq_n, 0);
      im2_mode = 1'b1; int_en = 1'b0;
      do_ack(4'b0000, oe1, v1, oe2, v2, oe3);
      chk("R5 no drive when disabled", oe1, 0);
      chk("R5 latch kept when disabled", irq_n, 0);
      int_en = 1'b1;
      do_ack(4'b0000, oe1, v1, oe2, v2, oe3);
      chk("R5 drive once enabled", oe1, 1);
      chk("R5 DMA0 vector", v1, 8'h04);
      chk("R5 cleared once enabled", irq_n, 1);

      // R9: raster arrives during a DMA1 acknowledge
      pulse(4'b0100);
      do_ack(4'b0001, oe1, v1, oe2, v2, oe3);
      chk("R9 vector at start", v1, 8'h02);
      chk("R9 vector unchanged", v2, 8'h02);
      chk("R9 oe held", oe2, 1);
      chk("R9 late request latched", irq_n, 0);
      do_ack(4'b0000, oe1, v1, oe2, v2, oe3);
      chk("R9 late raster serviced next", v1, 8'h06);

      // R10: write while pending; write to another address ignored
      pulse(4'b1000);
      write_reg(16'h6805, 8'hB1);
      chk("R10 write keeps pending", irq_n, 0);
      write_reg(16'h6804, 8'h70);
      do_ack(4'b0000, oe1, v1, oe2, v2, oe3);
      chk("R10 new base, other address ignored", v1, 8'hB0);

      // R6 R7 R8 sweep: every base nibble x every non-empty pending set
      for (int nb = 0; nb < 16; nb++) begin
         write_reg(16'h6805, {nb[3:0], 4'hA});
         for (int m = 1; m < 16; m++) begin
            pulse(m[3:0]);
            chk("R3 irq_n low when pending", irq_n, 0);
            p = m[3:0];
            while (p != 0) begin
               id = lowest(p);
               do_ack(4'b0000, oe1, v1, oe2, v2, oe3);
               chk("R4 sweep oe", oe1, 1);
               chk("R6 R7 sweep vector", v1, exp_vec(nb[3:0], id));
               p[id] = 1'b0;
               chk("R8 irq_n after service", irq_n, (p == 0) ? 1 : 0);
            end
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule